// File: doc/BRIEF.md
# Host Command Packet Assembler

This block turns one command-mode message into the 32-bit words that a display serial link controller loads into its transmit FIFO. A message is offered on a command handshake with its virtual channel, data type, byte count, a low-power request, an acknowledge request and a flag telling whether a read reply buffer is waiting. Its payload bytes follow on a separate byte stream, and the assembled words leave on a word stream. The first word is the packet header. It carries the first two payload bytes. The remaining bytes go out four to a word, lowest index in the lowest byte lane.

Alongside the words the block drives steady control levels for the current message. These select the large video FIFO when the message does not fit the small host FIFO, choose high-speed or low-power signalling, and ask for a bus turnaround when a reply is expected. A message too large for the video FIFO is refused outright. When a FIFO error flag is present as a message is taken, the block first pulses a FIFO reset. Once the last word has left, it raises a transmit trigger. The trigger stays high until the link reports completion, or until a programmable cycle limit expires.

All streams use valid/ready handshakes. A byte or word moves on a clock edge where both valid and ready are high. Ready never depends on valid. The payload source must keep `pay_data` stable and `pay_valid` high until the byte is taken, and it must send exactly `cmd_len` bytes for a message that is not refused. While `word_valid` is high and `word_ready` is low, the word output holds its value. Only one message is in flight: `cmd_ready` is high only when the block is idle.

Top module: `dsi_cmd_assembler`

## Requirements
- R1: The header word, which is always the first word out, holds the data type in bits 5:0 and the virtual channel in bits 7:6. It holds payload byte 0 in bits 15:8 when the length is at least 1, and payload byte 1 in bits 23:16 when the length is at least 2. Bits that carry no byte are zero.
- R2: Payload bytes 2 and up follow the header, four per word, with byte 2+4k+i in bits 8i+7:8i of word k+1. The last word is zero-padded. A message of length L sends 1 word when L is 2 or less, and 1+ceil((L-2)/4) words otherwise.
- R3: `use_video` is 1 for a message whose length exceeds 4*HOST_WORDS bytes and 0 otherwise. It is held from the cycle after acceptance.
- R4: A message longer than 4*VIDEO_WORDS bytes is refused. The block sets `rejected` from the next cycle until the next acceptance, consumes no payload, sends no words, does not raise the trigger and stays ready.
- R5: `bta_req` equals the acknowledge request OR the read-reply flag of the current message.
- R6: `hs_mode` is the inverse of the low-power request of the current message.
- R7: `trigger` rises in the cycle after the last word is taken. It stays 1 until `tx_done` is sampled high, and it is 0 from the cycle after that edge.
- R8: If `fifo_err` is high when a message is accepted, `fifo_rst` is high for exactly one cycle before any payload byte is taken. Otherwise it stays low.
- R9: On completion, `done` pulses for one cycle together with the trigger falling. `done_count` is 4 plus the length when no turnaround was requested, and 0 when one was.
- R10: If `tx_done` does not come, the trigger is high for exactly `timeout_limit` cycles. It then falls, `timed_out` is set until the next acceptance, and `done` does not pulse.
- R11: While `word_valid` is high and `word_ready` is low, `word_valid` stays high and `word_data` is unchanged.
- R12: `tx_done` has no effect while the trigger is low: `done` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Message offered |
| cmd_ready | output | 1 | Block idle and able to take a message |
| cmd_vc | input | 2 | Virtual channel |
| cmd_dtype | input | 6 | Packet data type |
| cmd_len | input | LEN_W | Payload length in bytes |
| cmd_lp | input | 1 | Request low-power transmission |
| cmd_ack | input | 1 | Request acknowledge from peripheral |
| cmd_rd | input | 1 | A read reply buffer of nonzero size waits |
| fifo_err | input | 1 | FIFO overflow or underflow flag |
| pay_valid | input | 1 | Payload byte valid |
| pay_ready | output | 1 | Payload byte taken on this edge if valid |
| pay_data | input | 8 | Payload byte |
| word_valid | output | 1 | FIFO word valid |
| word_ready | input | 1 | FIFO accepts the word |
| word_data | output | 32 | FIFO word |
| fifo_rst | output | 1 | One-cycle FIFO reset pulse |
| use_video | output | 1 | Route words to the video FIFO |
| hs_mode | output | 1 | High-speed signalling for this message |
| bta_req | output | 1 | Bus turnaround after the packet |
| trigger | output | 1 | Transmit trigger, high while in flight |
| tx_done | input | 1 | Link reports transmission complete |
| timeout_limit | input | TO_W | Cycles allowed for completion |
| timed_out | output | 1 | Last transfer timed out |
| rejected | output | 1 | Last message refused as too long |
| done | output | 1 | One-cycle completion pulse |
| done_count | output | LEN_W+1 | Completion result |

## Verification
The bench sweeps every length from zero to two bytes past the video limit. It does this under all eight combinations of low-power, acknowledge and read flags, with stalls on both streams. The sweep covers the lengths where the header is partly filled (0, 1, 2), where the last word is partly padded, and the exact FIFO boundaries. A packer that mis-counted lanes would shift or drop bytes, or emit one word too many or too few. A classifier off by one would route a message that just fits to the wrong FIFO, or refuse one it should accept. Further checks cover a FIFO reset fired on a clean message, a trigger that times out one cycle early or late, a timeout flag that survives the next message, and a completion pulse raised by a stray `tx_done` while idle.

// File: rtl/dsi_cmd_pkg.sv
package dsi_cmd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FLUSH,
    ST_GATHER,
    ST_EMIT,
    ST_WAIT
  } asm_state_t;
endpackage

// File: rtl/dsi_cmd_classify.sv
module dsi_cmd_classify #(
  parameter int HOST_WORDS  = 64,
  parameter int VIDEO_WORDS = 1024,
  parameter int LEN_W       = 16
) (
  input  logic [LEN_W-1:0] len,
  input  logic             lp,
  input  logic             ack,
  input  logic             rd,
  output logic             too_big,
  output logic             video,
  output logic             bta,
  output logic             hs
);
  localparam logic [LEN_W:0] HOST_LIM  = (LEN_W+1)'(4 * HOST_WORDS);
  localparam logic [LEN_W:0] VIDEO_LIM = (LEN_W+1)'(4 * VIDEO_WORDS);

  always_comb begin
    too_big = {1'b0, len} > VIDEO_LIM;
    video   = {1'b0, len} > HOST_LIM;
    bta     = ack | rd;
    hs      = ~lp;
  end
endmodule

// File: rtl/dsi_cmd_packer.sv
module dsi_cmd_packer #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [7:0]       hdr_byte,
  input  logic [LEN_W-1:0] len,
  input  logic             take,
  input  logic [7:0]       byte_in,
  input  logic             advance,
  output logic [31:0]      word,
  output logic [2:0]       need,
  output logic [LEN_W-1:0] rem
);
  logic [1:0]       lane;
  logic [2:0]       first_need;
  logic [2:0]       next_need;
  logic [LEN_W-1:0] rem_wide4;

  always_comb begin
    first_need = (len >= LEN_W'(2)) ? 3'd2 : {2'b00, len[0]};
    rem_wide4  = LEN_W'(4);
    next_need  = (rem >= rem_wide4) ? 3'd4 : {1'b0, rem[1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
      lane <= '0;
      need <= '0;
      rem  <= '0;
    end else if (load) begin
      word <= {24'h0, hdr_byte};
      lane <= 2'd1;
      need <= first_need;
      rem  <= len - {{(LEN_W-3){1'b0}}, first_need};
    end else if (take) begin
      word[{lane, 3'b000} +: 8] <= byte_in;
      lane <= lane + 2'd1;
      need <= need - 3'd1;
    end else if (advance) begin
      word <= '0;
      lane <= '0;
      need <= next_need;
      rem  <= rem - {{(LEN_W-3){1'b0}}, next_need};
    end
  end
endmodule

// File: rtl/dsi_cmd_trigger.sv
module dsi_cmd_trigger #(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            tx_done,
  input  logic [TO_W-1:0] limit,
  output logic            busy,
  output logic            finish,
  output logic            expire
);
  localparam logic [TO_W-1:0] ONE = TO_W'(1);
  logic [TO_W-1:0] cnt;

  always_comb begin
    finish = busy & tx_done;
    expire = busy & ~tx_done & (cnt == limit - ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (finish || expire) busy <= 1'b0;
      else                  cnt  <= cnt + ONE;
    end
  end
endmodule

// File: rtl/dsi_cmd_assembler.sv
module dsi_cmd_assembler #(
  parameter int HOST_WORDS  = 64,
  parameter int VIDEO_WORDS = 1024,
  parameter int LEN_W       = 16,
  parameter int TO_W        = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_vc,
  input  logic [5:0]       cmd_dtype,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic             cmd_lp,
  input  logic             cmd_ack,
  input  logic             cmd_rd,
  input  logic             fifo_err,
  input  logic             pay_valid,
  output logic             pay_ready,
  input  logic [7:0]       pay_data,
  output logic             word_valid,
  input  logic             word_ready,
  output logic [31:0]      word_data,
  output logic             fifo_rst,
  output logic             use_video,
  output logic             hs_mode,
  output logic             bta_req,
  output logic             trigger,
  input  logic             tx_done,
  input  logic [TO_W-1:0]  timeout_limit,
  output logic             timed_out,
  output logic             rejected,
  output logic             done,
  output logic [LEN_W:0]   done_count
);
  import dsi_cmd_pkg::*;

  asm_state_t       state;
  logic             too_big, video_c, bta_c, hs_c;
  logic             accept, load, take, advance, start;
  logic             finish, expire;
  logic [2:0]       need;
  logic [LEN_W-1:0] rem;
  logic [LEN_W-1:0] len_q;

  dsi_cmd_classify #(
    .HOST_WORDS(HOST_WORDS), .VIDEO_WORDS(VIDEO_WORDS), .LEN_W(LEN_W)
  ) u_class (
    .len(cmd_len), .lp(cmd_lp), .ack(cmd_ack), .rd(cmd_rd),
    .too_big(too_big), .video(video_c), .bta(bta_c), .hs(hs_c)
  );

  always_comb begin
    cmd_ready  = (state == ST_IDLE);
    accept     = cmd_ready & cmd_valid;
    load       = accept & ~too_big;
    pay_ready  = (state == ST_GATHER) && (need != 3'd0);
    take       = pay_ready & pay_valid;
    word_valid = (state == ST_EMIT);
    advance    = word_valid & word_ready & (rem != '0);
    start      = word_valid & word_ready & (rem == '0);
    fifo_rst   = (state == ST_FLUSH);
  end

  dsi_cmd_packer #(.LEN_W(LEN_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .load(load), .hdr_byte({cmd_vc, cmd_dtype}),
    .len(cmd_len), .take(take), .byte_in(pay_data), .advance(advance),
    .word(word_data), .need(need), .rem(rem)
  );

  dsi_cmd_trigger #(.TO_W(TO_W)) u_trig (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_done(tx_done),
    .limit(timeout_limit), .busy(trigger), .finish(finish), .expire(expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE:   if (load) state <= fifo_err ? ST_FLUSH : ST_GATHER;
        ST_FLUSH:  state <= ST_GATHER;
        ST_GATHER: if (need == 3'd0 || (take && need == 3'd1)) state <= ST_EMIT;
        ST_EMIT:   if (advance) state <= ST_GATHER;
                   else if (start) state <= ST_WAIT;
        ST_WAIT:   if (finish || expire) state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q      <= '0;
      use_video  <= 1'b0;
      hs_mode    <= 1'b1;
      bta_req    <= 1'b0;
      rejected   <= 1'b0;
      timed_out  <= 1'b0;
      done       <= 1'b0;
      done_count <= '0;
    end else begin
      done <= finish;
      if (accept) begin
        len_q     <= cmd_len;
        use_video <= video_c;
        hs_mode   <= hs_c;
        bta_req   <= bta_c;
        rejected  <= too_big;
        timed_out <= 1'b0;
      end
      if (expire) timed_out <= 1'b1;
      if (finish) done_count <= bta_req ? '0 : ({1'b0, len_q} + (LEN_W+1)'(4));
    end
  end
endmodule

// File: rtl/dsi_cmd_checker.sv
module dsi_cmd_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_ready,
  input logic        pay_ready,
  input logic        word_valid,
  input logic        word_ready,
  input logic [31:0] word_data,
  input logic        fifo_rst,
  input logic        trigger,
  input logic        tx_done,
  input logic        timed_out,
  input logic        rejected,
  input logic        done
);
  a_r11_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && !word_ready |=> word_valid && $stable(word_data));

  a_r7_trigger_hold: assert property (@(posedge clk) disable iff (!rst_n)
    trigger && !tx_done |=> trigger || timed_out);

  a_r8_flush_once: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rst |=> !fifo_rst);

  a_r10_expire_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timed_out) |-> !trigger && !done);

  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !trigger && cmd_ready);

  a_r4_reject_silent: assert property (@(posedge clk) disable iff (!rst_n)
    rejected |-> !word_valid && !pay_ready && !trigger);

  a_r2_one_side: assert property (@(posedge clk) disable iff (!rst_n)
    !(pay_ready && word_valid));
endmodule

bind dsi_cmd_assembler dsi_cmd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .pay_ready(pay_ready),
  .word_valid(word_valid), .word_ready(word_ready), .word_data(word_data),
  .fifo_rst(fifo_rst), .trigger(trigger), .tx_done(tx_done),
  .timed_out(timed_out), .rejected(rejected), .done(done)
);

// File: tb/dsi_cmd_assembler_test.sv
module dsi_cmd_assembler_test;
  localparam int HW = 2;
  localparam int VW = 4;
  localparam int LW = 8;
  localparam int TW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [1:0] cmd_vc = '0;
  logic [5:0] cmd_dtype = '0;
  logic [LW-1:0] cmd_len = '0;
  logic cmd_lp = 1'b0, cmd_ack = 1'b0, cmd_rd = 1'b0, fifo_err = 1'b0;
  logic pay_valid = 1'b0, pay_ready;
  logic [7:0] pay_data = '0;
  logic word_valid, word_ready = 1'b0;
  logic [31:0] word_data;
  logic fifo_rst, use_video, hs_mode, bta_req, trigger;
  logic tx_done = 1'b0;
  logic [TW-1:0] timeout_limit = TW'(200);
  logic timed_out, rejected, done;
  logic [LW:0] done_count;

  int nchk = 0, nfail = 0, rst_seen = 0, cyc = 0;
  logic [7:0] pbytes [0:31];

  always #5 clk = ~clk;

  dsi_cmd_assembler #(.HOST_WORDS(HW), .VIDEO_WORDS(VW), .LEN_W(LW), .TO_W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_vc(cmd_vc), .cmd_dtype(cmd_dtype), .cmd_len(cmd_len), .cmd_lp(cmd_lp),
    .cmd_ack(cmd_ack), .cmd_rd(cmd_rd), .fifo_err(fifo_err),
    .pay_valid(pay_valid), .pay_ready(pay_ready), .pay_data(pay_data),
    .word_valid(word_valid), .word_ready(word_ready), .word_data(word_data),
    .fifo_rst(fifo_rst), .use_video(use_video), .hs_mode(hs_mode),
    .bta_req(bta_req), .trigger(trigger), .tx_done(tx_done),
    .timeout_limit(timeout_limit), .timed_out(timed_out), .rejected(rejected),
    .done(done), .done_count(done_count)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (fifo_rst) rst_seen <= rst_seen + 1;
  end

  task automatic chk(input string r, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input int k, input int len,
                                            input logic [1:0] vc, input logic [5:0] dt);
    logic [31:0] w;
    w = '0;
    if (k == 0) begin
      w[7:0] = {vc, dt};
      if (len > 0) w[15:8]  = pbytes[0];
      if (len > 1) w[23:16] = pbytes[1];
    end else begin
      for (int i = 0; i < 4; i++)
        if (2 + 4*(k-1) + i < len) w[8*i +: 8] = pbytes[2 + 4*(k-1) + i];
    end
    return w;
  endfunction

  task automatic run_msg(input int m, input int len, input bit lp, input bit ack,
                         input bit rd, input bit fe, input logic [1:0] vc,
                         input logic [5:0] dt, input bit hang);
    int nw, d, hi;
    bit big;
    big = (len > 4*VW);
    nw = big ? 0 : ((len <= 2) ? 1 : 1 + (len - 2 + 3) / 4);
    for (int i = 0; i < 32; i++) pbytes[i] = 8'(m*7 + i*13 + 1);
    @(negedge clk);
    rst_seen = 0;
    fork
      begin
        cmd_valid = 1'b1; cmd_len = LW'(len); cmd_lp = lp; cmd_ack = ack;
        cmd_rd = rd; cmd_vc = vc; cmd_dtype = dt; fifo_err = fe;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0; fifo_err = 1'b0;
        chk("R4 rejected flag", rejected, big);
        chk("R10 timeout cleared on accept", timed_out, 0);
        if (!big) begin
          chk("R3 fifo select", use_video, len > 4*HW);
          chk("R5 turnaround", bta_req, ack | rd);
          chk("R6 high speed", hs_mode, !lp);
        end
      end
      begin
        if (!big) begin
          for (int i = 0; i < len; i++) begin
            if ((i + m) % 5 == 0) begin
              pay_valid = 1'b0;
              @(negedge clk);
            end
            pay_valid = 1'b1; pay_data = pbytes[i];
            while (!pay_ready) @(negedge clk);
            @(negedge clk);
          end
          pay_valid = 1'b0;
        end
      end
      begin
        int got;
        got = 0;
        while (got < nw) begin
          @(negedge clk);
          word_ready = ((cyc + m) % 3) != 0;
          if (word_valid && word_ready) begin
            chk(got == 0 ? "R1 header word" : "R2 payload word",
                word_data, exp_word(got, len, vc, dt));
            got++;
          end
        end
      end
    join
    if (big) begin
      repeat (3) @(negedge clk);
      chk("R4 no words", word_valid, 0);
      chk("R4 no trigger", trigger, 0);
      chk("R4 no payload taken", pay_ready, 0);
      chk("R4 still ready", cmd_ready, 1);
      return;
    end
    @(negedge clk);
    word_ready = 1'b0;
    chk("R2 no extra word", word_valid, 0);
    chk("R7 trigger raised", trigger, 1);
    chk("R8 fifo reset pulses", rst_seen, fe ? 1 : 0);
    if (hang) begin
      hi = 0;
      while (trigger && hi < 1000) begin
        hi++;
        @(negedge clk);
      end
      chk("R10 trigger high cycles", hi, timeout_limit);
      chk("R10 timed_out set", timed_out, 1);
      chk("R10 no done", done, 0);
      return;
    end
    d = m % 3;
    for (int i = 0; i < d; i++) begin
      @(negedge clk);
      chk("R7 trigger held", trigger, 1);
    end
    tx_done = 1'b1;
    @(negedge clk);
    tx_done = 1'b0;
    chk("R7 trigger cleared", trigger, 0);
    chk("R9 done pulse", done, 1);
    chk("R9 done count", done_count, (ack || rd) ? 0 : len + 4);
    @(negedge clk);
    chk("R9 done single", done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL R7 watchdog actual=hung expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 reset trigger", trigger, 0);
    chk("R9 reset done", done, 0);
    chk("R2 reset word_valid", word_valid, 0);
    chk("R4 reset ready", cmd_ready, 1);
    chk("R10 reset timed_out", timed_out, 0);

    for (int m = 0; m < 152; m++) begin
      int f;
      f = m / 19;
      run_msg(m, m % 19, f[0], f[1], f[2], (m % 4) == 1, 2'(m), 6'(m * 5), 1'b0);
    end

    timeout_limit = TW'(20);
    run_msg(200, 5, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 6'h29, 1'b1);
    timeout_limit = TW'(200);
    run_msg(201, 3, 1'b1, 1'b0, 1'b0, 1'b1, 2'd2, 6'h15, 1'b0);

    @(negedge clk);
    tx_done = 1'b1;
    @(negedge clk);
    tx_done = 1'b0;
    chk("R12 idle done ignored", done, 0);
    chk("R12 idle trigger low", trigger, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule